// File: doc/BRIEF.md
# Prescaled 16-bit tick counter with byte-wide bus access

This block is a 16-bit up-counter for a peripheral reached over an 8-bit register bus. It counts either an internal instruction tick, one for every four system clocks, or rising edges seen on an external clock pin. The selected tick passes through a power-of-two prescaler and is gated by a run bit before it reaches the counter. A rollover from all-ones to zero raises a sticky overflow flag that also drives an interrupt line. A pulse from a compare unit can zero the counter when that path is enabled.

The internal tick comes from a four-state phase machine. Its states are PH_Q1, PH_Q2, PH_Q3 and PH_Q4. Its transitions are PH_Q1→PH_Q2, PH_Q2→PH_Q3, PH_Q3→PH_Q4 and PH_Q4→PH_Q1, one per system clock. The tick is issued in PH_Q4. External edges are found by registering the pin and comparing adjacent stages. In the synchronized mode one extra register stage is added in front of that compare, and in the direct mode it is left out. The design stays in one clock domain in both modes.

In wide access mode the bus sees a coherent 16-bit value. Reading the low byte copies the live high byte into a holding register, and the high byte is then read from that register. Writing the high byte fills the holding register, and the following low-byte write loads both bytes at once.

Top module: `tick_counter16`

## Requirements
- R1: After reset, the count, control register, holding register and overflow flag are all zero, and `ovf_irq` is low.
- R2: The bus address selects: 0 for the count low byte, 1 for the count high byte, 2 for control and 3 for the flag. Control bits are: bit0 run, bit1 source (1 = external pin), bit2 synchronized edge mode, bits4:3 prescale, bit5 compare-clear enable and bit6 wide mode. Control reads back exactly what was written.
- R3: With source 0, the phase machine cycles PH_Q1→PH_Q2→PH_Q3→PH_Q4→PH_Q1 and yields exactly one tick per four system clocks.
- R4: The prescale field value p passes one of every 2^p source ticks to the counter (1, 2, 4 or 8). Any write to the count resets the prescaler phase.
- R5: With source 1, each rising edge of `ext_clk` is one source tick. In direct mode (bit2 = 0) the count changes on the second clock edge after the pin rises. In synchronized mode (bit2 = 1) it changes on the third.
- R6: While run is 0, the count holds its value.
- R7: An increment from 0xFFFF to 0x0000 sets the overflow flag, which is read as bit0 at address 3 and drives `ovf_irq`. Writing 0 to that bit clears it. A set in the same cycle as a clear leaves the flag set.
- R8: A `cmp_trig` pulse zeroes the count when the compare-clear enable is 1, and has no effect when it is 0.
- R9: A compare clear wins over a simultaneous increment or bus write to the count. A clear at 0xFFFF with an increment pending does not set the overflow flag.
- R10: In wide mode, a read of address 0 copies the live high byte into the holding register, and reads of address 1 return the holding register.
- R11: In wide mode, a write to address 1 changes only the holding register. A write to address 0 loads the holding register into the high byte and the bus data into the low byte in the same cycle.
- R12: In byte mode, addresses 0 and 1 read and write the live low and high count bytes directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 2 | Register select |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe (enables the read-side latch in wide mode) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the selected register (combinational) |
| ext_clk | input | 1 | External count clock pin |
| cmp_trig | input | 1 | Clear pulse from the compare unit |
| ovf_irq | output | 1 | Overflow interrupt, equal to the sticky flag |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a compare clear and a counter increment. The second pair is a hardware overflow set and a software flag clear. The bench raises the external pin in direct mode, which places the resulting increment exactly two edges later. It then times `cmp_trig`, or a flag write, so that it is sampled on that same edge. Coincidence with a preloaded 0xFFFF is judged by a zero count with the flag still low. Coincidence with the flag write is judged by the flag remaining set.

// File: rtl/tc16_pkg.sv
package tc16_pkg;

    // Prescale field width; the divider reaches 2**(2**PS_W - 1).
    localparam int PS_W = 2;

    // Control register bit positions.
    localparam int C_RUN   = 0;
    localparam int C_SRC   = 1;
    localparam int C_SYNC  = 2;
    localparam int C_PS_LO = 3;
    localparam int C_CLREN = 5;
    localparam int C_WIDE  = 6;

    typedef enum logic [1:0] {
        A_CNT_LO = 2'd0,
        A_CNT_HI = 2'd1,
        A_CTRL   = 2'd2,
        A_FLAG   = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        PH_Q1 = 2'd0,
        PH_Q2 = 2'd1,
        PH_Q3 = 2'd2,
        PH_Q4 = 2'd3
    } cyc_phase_e;

endpackage

// File: rtl/tc16_tick_src.sv
module tc16_tick_src
    import tc16_pkg::*;
#(
    parameter int EXTRA_SYNC = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_in,
    input  logic src_ext,
    input  logic sync_on,
    output logic raw_tick
);
    localparam int DEPTH = 2 + EXTRA_SYNC;

    cyc_phase_e       phase_q, phase_d;
    logic [DEPTH-1:0] pin_sr;
    logic             inst_tick, edge_direct, edge_synced;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_Q1;
        else        phase_q <= phase_d;
    end

    // Next state
    always_comb begin
        unique case (phase_q)
            PH_Q1: phase_d = PH_Q2;
            PH_Q2: phase_d = PH_Q3;
            PH_Q3: phase_d = PH_Q4;
            PH_Q4: phase_d = PH_Q1;
        endcase
    end

    // Pin sampling chain
    always_ff @(posedge clk) begin
        if (!rst_n) pin_sr <= '0;
        else        pin_sr <= {pin_sr[DEPTH-2:0], ext_in};
    end

    // Outputs
    always_comb begin
        inst_tick   = (phase_q == PH_Q4);
        edge_direct = pin_sr[0] & ~pin_sr[1];
        edge_synced = pin_sr[DEPTH-2] & ~pin_sr[DEPTH-1];
        if (src_ext) raw_tick = sync_on ? edge_synced : edge_direct;
        else         raw_tick = inst_tick;
    end

    a_r3_phase_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        phase_q == PH_Q4 |=> phase_q == PH_Q1);
    a_r3_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        inst_tick |=> !inst_tick);

endmodule

// File: rtl/tc16_prescale.sv
module tc16_prescale
    import tc16_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            raw_tick,
    input  logic            run,
    input  logic [PS_W-1:0] ps_sel,
    input  logic            sclr,
    output logic            pre_tick
);
    localparam int PC_W = (1 << PS_W) - 1;

    logic [PC_W-1:0] pre_cnt, div_m1;
    logic            step;

    always_comb begin
        div_m1   = PC_W'((32'd1 << ps_sel) - 32'd1);
        step     = run & raw_tick;
        pre_tick = step & (pre_cnt >= div_m1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || sclr) pre_cnt <= '0;
        else if (step)      pre_cnt <= pre_tick ? '0 : pre_cnt + 1'b1;
    end

    a_r4_write_resets_phase: assert property (@(posedge clk) disable iff (!rst_n)
        sclr |=> pre_cnt == '0);
    a_r4_wrap_after_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (pre_tick && !sclr) |=> pre_cnt == '0);

endmodule

// File: rtl/tc16_core.sv
module tc16_core #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              clr,
    input  logic              ld_lo,
    input  logic              ld_hi,
    input  logic [BYTE_W-1:0] lo_val,
    input  logic [BYTE_W-1:0] hi_val,
    input  logic              flag_wr,
    input  logic              flag_wdata,
    output logic [2*BYTE_W-1:0] cnt,
    output logic              flag
);
    logic ld_any, wrap;

    always_comb begin
        ld_any = ld_lo | ld_hi;
        wrap   = inc & ~clr & ~ld_any & (&cnt);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (ld_any) begin
            if (ld_lo) cnt[BYTE_W-1:0]        <= lo_val;
            if (ld_hi) cnt[2*BYTE_W-1:BYTE_W] <= hi_val;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                       flag <= 1'b0;
        else if (wrap)                    flag <= 1'b1;
        else if (flag_wr && !flag_wdata)  flag <= 1'b0;
    end

    a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> cnt == '0);
    a_r7_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !clr && !ld_any && cnt == '1) |=> flag);
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !(flag_wr && !flag_wdata)) |=> flag);
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !clr && !ld_any) |=> $stable(cnt));

endmodule

// File: rtl/tick_counter16.sv
module tick_counter16
    import tc16_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       addr,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    input  logic             ext_clk,
    input  logic             cmp_trig,
    output logic             ovf_irq
);
    localparam int CNT_W = 2 * BUS_W;

    reg_addr_e        sel;
    logic [BUS_W-1:0] ctrl_q, hbuf_q, hi_val;
    logic [CNT_W-1:0] cnt;
    logic             wide, wr_lo, wr_hi, ld_hi, trig_clr;
    logic             raw_tick, pre_tick, flag;

    always_comb begin
        sel      = reg_addr_e'(addr);
        wide     = ctrl_q[C_WIDE];
        wr_lo    = wr_en && sel == A_CNT_LO;
        wr_hi    = wr_en && sel == A_CNT_HI;
        ld_hi    = wide ? wr_lo : wr_hi;
        hi_val   = wide ? hbuf_q : wdata;
        trig_clr = cmp_trig & ctrl_q[C_CLREN];
        ovf_irq  = flag;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            hbuf_q <= '0;
        end else begin
            if (wr_en && sel == A_CTRL) ctrl_q <= wdata;
            if (wide && wr_hi)
                hbuf_q <= wdata;
            else if (wide && rd_en && sel == A_CNT_LO)
                hbuf_q <= cnt[CNT_W-1:BUS_W];
        end
    end

    always_comb begin
        unique case (sel)
            A_CNT_LO: rdata = cnt[BUS_W-1:0];
            A_CNT_HI: rdata = wide ? hbuf_q : cnt[CNT_W-1:BUS_W];
            A_CTRL:   rdata = ctrl_q;
            A_FLAG:   rdata = {{(BUS_W-1){1'b0}}, flag};
        endcase
    end

    tc16_tick_src u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_in   (ext_clk),
        .src_ext  (ctrl_q[C_SRC]),
        .sync_on  (ctrl_q[C_SYNC]),
        .raw_tick (raw_tick)
    );

    tc16_prescale u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_tick (raw_tick),
        .run      (ctrl_q[C_RUN]),
        .ps_sel   (ctrl_q[C_PS_LO +: PS_W]),
        .sclr     (wr_lo | ld_hi),
        .pre_tick (pre_tick)
    );

    tc16_core #(.BYTE_W(BUS_W)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .inc        (pre_tick),
        .clr        (trig_clr),
        .ld_lo      (wr_lo),
        .ld_hi      (ld_hi),
        .lo_val     (wdata),
        .hi_val     (hi_val),
        .flag_wr    (wr_en && sel == A_FLAG),
        .flag_wdata (wdata[0]),
        .cnt        (cnt),
        .flag       (flag)
    );

    a_r10_read_latch: assert property (@(posedge clk) disable iff (!rst_n)
        (wide && rd_en && sel == A_CNT_LO && !wr_en) |=> hbuf_q == $past(cnt[CNT_W-1:BUS_W]));
    a_r8_no_clear_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q[C_CLREN] && !ctrl_q[C_RUN] && !wr_en) |=> $stable(cnt));

endmodule

// File: tb/tick_counter16_test.sv
module tick_counter16_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] addr = 2'd0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       ext_clk = 1'b0, cmp_trig = 1'b0;
    logic       ovf_irq;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    tick_counter16 uut (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .ext_clk(ext_clk), .cmp_trig(cmp_trig),
        .ovf_irq(ovf_irq)
    );

    // Vector: {write, addr[1:0], data[7:0], requirement number[3:0]}; data is expected value on reads.
    localparam int NV = 17;
    localparam logic [14:0] VEC [NV] = '{
        {1'b1, 2'd2, 8'h40, 4'd2},   // R2 wide mode on
        {1'b0, 2'd2, 8'h40, 4'd2},   // R2 readback
        {1'b1, 2'd1, 8'h12, 4'd11},  // R11 to holding register
        {1'b1, 2'd0, 8'h34, 4'd11},  // R11 load both bytes
        {1'b0, 2'd0, 8'h34, 4'd10},  // R10 latches high byte
        {1'b0, 2'd1, 8'h12, 4'd10},
        {1'b1, 2'd1, 8'hAB, 4'd11},  // R11 holding only
        {1'b1, 2'd2, 8'h00, 4'd12},  // R12 byte mode
        {1'b0, 2'd2, 8'h00, 4'd2},
        {1'b0, 2'd1, 8'h12, 4'd11},  // live high untouched
        {1'b0, 2'd0, 8'h34, 4'd11},
        {1'b1, 2'd1, 8'h56, 4'd12},
        {1'b0, 2'd1, 8'h56, 4'd12},
        {1'b1, 2'd0, 8'h78, 4'd12},
        {1'b0, 2'd0, 8'h78, 4'd12},
        {1'b0, 2'd1, 8'h56, 4'd12},
        {1'b0, 2'd3, 8'h00, 4'd7}
    };

    task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic load16(input logic [15:0] v);
        bus_wr(2'd0, v[7:0]);
        bus_wr(2'd1, v[15:8]);
    endtask

    task automatic read16(output logic [15:0] v);
        logic [7:0] lo, hi;
        bus_rd(2'd0, lo);
        bus_rd(2'd1, hi);
        v = {hi, lo};
    endtask

    task automatic pin_pulse();
        @(negedge clk); ext_clk = 1'b1;
        repeat (2) @(negedge clk);
        @(negedge clk); ext_clk = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic trig_pulse();
        @(negedge clk); cmp_trig = 1'b1;
        @(negedge clk); cmp_trig = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  r8;
        logic [15:0] r16;

        repeat (4) @(negedge clk);
        // R1 reset state
        for (int a = 0; a < 4; a++) begin
            addr = 2'(a);
            #1 chk({8'd0, rdata}, 16'd0, "R1 register after reset");
        end
        chk({15'd0, ovf_irq}, 16'd0, "R1 irq after reset");
        rst_n = 1'b1;

        // Register access table (R2, R10, R11, R12)
        for (int i = 0; i < NV; i++) begin
            if (VEC[i][14]) bus_wr(VEC[i][13:12], VEC[i][11:4]);
            else begin
                bus_rd(VEC[i][13:12], r8);
                chk({8'd0, r8}, {8'd0, VEC[i][11:4]}, $sformatf("R%0d table row %0d", VEC[i][3:0], i));
            end
        end

        // R3: internal source, divide by 1, 40 clock window
        bus_wr(2'd2, 8'h00);
        load16(16'h0000);
        bus_wr(2'd2, 8'h01);
        repeat (38) @(negedge clk);
        bus_wr(2'd2, 8'h00);
        read16(r16);
        chk(r16, 16'd10, "R3 one tick per four clocks");

        // R4: internal source, divide by 2, 64 clock window
        load16(16'h0000);
        bus_wr(2'd2, 8'h09);
        repeat (62) @(negedge clk);
        bus_wr(2'd2, 8'h00);
        read16(r16);
        chk(r16, 16'd8, "R4 divide by two");

        // R6: hold while stopped
        repeat (20) @(negedge clk);
        read16(r16);
        chk(r16, 16'd8, "R6 hold while run off");

        // R4: external source direct, divide by 8, 20 edges
        load16(16'h0000);
        bus_wr(2'd2, 8'h1B);
        for (int p = 0; p < 20; p++) pin_pulse();
        bus_wr(2'd2, 8'h00);
        read16(r16);
        chk(r16, 16'd2, "R4 divide by eight on pin edges");

        // R5: synchronized mode, five edges
        load16(16'h0000);
        bus_wr(2'd2, 8'h07);
        for (int p = 0; p < 5; p++) pin_pulse();
        bus_wr(2'd2, 8'h00);
        read16(r16);
        chk(r16, 16'd5, "R5 synchronized edge count");

        // R5: latency, direct mode
        load16(16'h0000);
        bus_wr(2'd2, 8'h03);
        addr = 2'd0;
        @(negedge clk); ext_clk = 1'b1;
        @(negedge clk);
        @(negedge clk); #1 chk({8'd0, rdata}, 16'd1, "R5 direct latency two edges");
        ext_clk = 1'b0;
        repeat (4) @(negedge clk);
        bus_wr(2'd2, 8'h00);

        // R5: latency, synchronized mode
        load16(16'h0000);
        bus_wr(2'd2, 8'h07);
        addr = 2'd0;
        @(negedge clk); ext_clk = 1'b1;
        @(negedge clk);
        @(negedge clk); #1 chk({8'd0, rdata}, 16'd0, "R5 synchronized not yet counted");
        @(negedge clk); #1 chk({8'd0, rdata}, 16'd1, "R5 synchronized latency three edges");
        ext_clk = 1'b0;
        repeat (4) @(negedge clk);
        bus_wr(2'd2, 8'h00);

        // R7: overflow sets flag, write 0 clears
        load16(16'hFFFE);
        bus_wr(2'd2, 8'h03);
        pin_pulse(); pin_pulse();
        bus_wr(2'd2, 8'h00);
        chk({15'd0, ovf_irq}, 16'd1, "R7 irq after wrap");
        read16(r16);
        chk(r16, 16'h0000, "R7 count after wrap");
        bus_rd(2'd3, r8);
        chk({8'd0, r8}, 16'd1, "R7 flag register");
        bus_wr(2'd3, 8'h00);
        chk({15'd0, ovf_irq}, 16'd0, "R7 flag cleared by write");

        // R7: set and clear on the same edge, set wins
        load16(16'hFFFF);
        bus_wr(2'd2, 8'h03);
        @(negedge clk); ext_clk = 1'b1;
        @(negedge clk); addr = 2'd3; wdata = 8'h00; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0; ext_clk = 1'b0;
        repeat (3) @(negedge clk);
        bus_wr(2'd2, 8'h00);
        chk({15'd0, ovf_irq}, 16'd1, "R7 set wins over clear");
        bus_wr(2'd3, 8'h00);

        // R8: trigger ignored when disabled, clears when enabled
        load16(16'h1234);
        trig_pulse();
        read16(r16);
        chk(r16, 16'h1234, "R8 trigger ignored when disabled");
        bus_wr(2'd2, 8'h20);
        trig_pulse();
        read16(r16);
        chk(r16, 16'h0000, "R8 trigger clears when enabled");

        // R9: clear and increment at 0xFFFF on the same edge
        bus_wr(2'd2, 8'h00);
        load16(16'hFFFF);
        bus_wr(2'd2, 8'h23);
        @(negedge clk); ext_clk = 1'b1;
        @(negedge clk); cmp_trig = 1'b1;
        @(negedge clk); cmp_trig = 1'b0; ext_clk = 1'b0;
        repeat (3) @(negedge clk);
        bus_wr(2'd2, 8'h20);
        read16(r16);
        chk(r16, 16'h0000, "R9 clear beats increment");
        chk({15'd0, ovf_irq}, 16'd0, "R9 no flag when clear wins");

        // R9: clear and bus write on the same edge
        @(negedge clk); addr = 2'd0; wdata = 8'h55; wr_en = 1'b1; cmp_trig = 1'b1;
        @(negedge clk); wr_en = 1'b0; cmp_trig = 1'b0;
        bus_rd(2'd0, r8);
        chk({8'd0, r8}, 16'h0000, "R9 clear beats write");

        // R10: buffered high byte survives a live change
        bus_wr(2'd2, 8'h40);
        bus_wr(2'd1, 8'h12);
        bus_wr(2'd0, 8'h34);
        bus_rd(2'd0, r8);
        chk({8'd0, r8}, 16'h0034, "R10 low byte read");
        bus_wr(2'd2, 8'h60);
        trig_pulse();
        bus_rd(2'd1, r8);
        chk({8'd0, r8}, 16'h0012, "R10 high byte from holding register");
        bus_wr(2'd2, 8'h00);
        bus_rd(2'd1, r8);
        chk({8'd0, r8}, 16'h0000, "R10 live high byte was cleared");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule